// File: doc/BRIEF.md
# Burst Column Sequencer

This block supplies the column address for every beat of one SDRAM read or write burst. When a burst is launched it samples a 12-bit mode word, the 10-bit starting column and whether the access is a write. From the mode word it works out how many beats to produce (1, 2, 4, 8 or an endless full-page run) and which ordering to use (counting up, or XOR-style interleaving). It then presents one column per clock until the burst is exhausted or a stop request arrives.

A memory controller drives `start` on the clock it issues the column command and takes `col_out` while `col_valid` is high. `last` flags the closing beat of a finite burst. A reserved length code makes the burst one beat long and sets a flag that only reset clears.

Top module: `burst_col_gen`

## Requirements
- R1: Mode bits [2:0] select the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 with bit 3 = 0 gives full page.
- R2: With bit 3 = 0, the low bits count up and wrap inside the aligned block of the burst length (start 2, length 4 gives 2,3,0,1).
- R3: With bit 3 = 1, beat k carries the start column XOR k in its low bits (start 5, length 8 gives 5,4,7,6,1,0,3,2).
- R4: For lengths 2, 4 and 8, the column bits above the low 1, 2 or 3 bits equal those of the start column on every beat.
- R5: A full-page burst starts at any column 0..1023, adds 1 modulo 1024 on each beat, and never ends by itself.
- R6: At length 1 exactly one beat carrying the start column is produced, whatever bit 3 holds.
- R7: When mode bit 9 = 1, a write burst is one beat long and a read burst keeps its programmed length.
- R8: Codes 100, 101, 110, and 111 with bit 3 = 1, give a one-beat burst and set `mode_err`, which stays set until reset.
- R9: `last` is high on the final beat of a finite burst only, and never during a full-page burst.
- R10: `stop` high during a valid beat makes that beat the final one; `col_valid` is low on the next clock unless `start` is also high.
- R11: `start` during a burst drops it; the new burst's first beat appears on the next clock.
- R12: After reset `col_valid`, `last`, `mode_err` are 0 and `col_out` is 0; `col_out` is 0 whenever `col_valid` is 0. The first beat appears in the clock after the `start` edge and beats follow one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a burst on this edge |
| start_wr | input | 1 | Launched burst is a write |
| start_col | input | 10 | Starting column |
| mode_word | input | 12 | Mode word: [2:0] length, [3] ordering, [9] single write |
| stop | input | 1 | End the burst after the current beat |
| col_out | output | 10 | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last | output | 1 | Current beat is the final one of a finite burst |
| mode_err | output | 1 | Sticky reserved-code flag |

## Verification
Every output is registered state, so the effect of a `start`, `stop` or mode word sampled at a rising edge is due at the outputs in the very next cycle. Each later beat follows one cycle after the one before it. The bench keeps a behavioural model that takes the same inputs at each rising edge and updates its expectation then. It compares `col_out`, `col_valid`, `last` and `mode_err` at the falling edge, half a period after the design's registers have settled. Launches, stops and restarts are driven at falling edges, so every input is stable at the edge where it is sampled.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Log2 of the beat count for finite bursts (0..3 -> 1..8 beats).
  localparam int LG_W = 2;

  typedef struct packed {
    logic [LG_W-1:0] lg;     // log2 of finite burst length
    logic            full;   // full-page run
    logic            intlv;  // XOR ordering
    logic            bad;    // reserved code seen
  } burst_cfg_t;

  localparam burst_cfg_t CFG_IDLE = '{lg: '0, full: 1'b0, intlv: 1'b0, bad: 1'b0};
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
#(
  parameter int MODE_W      = 12,
  parameter int LEN_LSB     = 0,
  parameter int ORDER_BIT   = 3,
  parameter int WSINGLE_BIT = 9
) (
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_write,
  output burst_cfg_t        cfg
);
  localparam int LEN_W = 3;

  logic [LEN_W-1:0] len_code;
  logic             order_bit;
  logic             wsingle;

  assign len_code  = mode_word[LEN_LSB +: LEN_W];
  assign order_bit = mode_word[ORDER_BIT];
  assign wsingle   = mode_word[WSINGLE_BIT];

  always_comb begin
    cfg = CFG_IDLE;
    unique case (len_code)
      3'b000: cfg.lg = 2'd0;
      3'b001: cfg.lg = 2'd1;
      3'b010: cfg.lg = 2'd2;
      3'b011: cfg.lg = 2'd3;
      3'b111: begin
        if (order_bit) cfg.bad  = 1'b1;
        else           cfg.full = 1'b1;
      end
      default: cfg.bad = 1'b1;
    endcase
    // Single-location writes override the programmed length.
    if (wsingle && is_write) begin
      cfg.lg   = '0;
      cfg.full = 1'b0;
    end
    // Ordering only matters for multi-beat finite bursts.
    cfg.intlv = order_bit && !cfg.full && !cfg.bad && (cfg.lg != '0);
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       cfg_in,
  output logic             active,
  output logic [COL_W-1:0] beat_idx,
  output logic [COL_W-1:0] base_col,
  output burst_cfg_t       cfg_q,
  output logic             final_beat
);
  function automatic logic [COL_W-1:0] final_index(input logic [LG_W-1:0] lg);
    final_index = COL_W'((1 << lg) - 1);
  endfunction

  assign final_beat = active && !cfg_q.full && (beat_idx == final_index(cfg_q.lg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat_idx <= '0;
      base_col <= '0;
      cfg_q    <= CFG_IDLE;
    end else if (start) begin
      active   <= 1'b1;
      beat_idx <= '0;
      base_col <= start_col;
      cfg_q    <= cfg_in;
    end else if (active) begin
      if (stop || final_beat) begin
        active   <= 1'b0;
        beat_idx <= '0;
      end else begin
        beat_idx <= beat_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] low_mask(input logic [LG_W-1:0] lg);
    low_mask = COL_W'((1 << lg) - 1);
  endfunction

  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] i,
                                               input logic [LG_W-1:0] lg);
    logic [COL_W-1:0] m;
    m = low_mask(lg);
    seq_col = (b & ~m) | ((b + i) & m);
  endfunction

  function automatic logic [COL_W-1:0] xor_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] i,
                                               input logic [LG_W-1:0] lg);
    logic [COL_W-1:0] m;
    m = low_mask(lg);
    xor_col = (b & ~m) | ((b ^ i) & m);
  endfunction

  always_comb begin
    if (cfg.full)       col = base_col + beat_idx;
    else if (cfg.intlv) col = xor_col(base_col, beat_idx, cfg.lg);
    else                col = seq_col(base_col, beat_idx, cfg.lg);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              last,
  output logic              mode_err
);
  burst_cfg_t       cfg_dec;
  burst_cfg_t       cfg_run;
  logic             run_active;
  logic             run_full;
  logic             run_final;
  logic [COL_W-1:0] run_idx;
  logic [COL_W-1:0] run_base;
  logic [COL_W-1:0] run_col;

  burst_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .mode_word (mode_word),
    .is_write  (start_wr),
    .cfg       (cfg_dec)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .start_col  (start_col),
    .cfg_in     (cfg_dec),
    .active     (run_active),
    .beat_idx   (run_idx),
    .base_col   (run_base),
    .cfg_q      (cfg_run),
    .final_beat (run_final)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_col (run_base),
    .beat_idx (run_idx),
    .cfg      (cfg_run),
    .col      (run_col)
  );

  assign run_full  = run_active && cfg_run.full;
  assign col_valid = run_active;
  assign col_out   = run_active ? run_col : '0;
  assign last      = run_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mode_err <= 1'b0;
    else if (start && cfg_dec.bad) mode_err <= 1'b1;
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last,
  input logic             mode_err,
  input logic             run_full
);
  a_r11_restart_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_out == $past(start_col));

  a_r5_full_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && run_full && !stop && !start |=>
      col_valid && col_out == COL_W'($past(col_out) + 1'b1));

  a_r9_no_last_full: assert property (@(posedge clk) disable iff (!rst_n)
    run_full |-> !last);

  a_r9_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !col_valid);

  a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && stop && !start |=> !col_valid);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> col_out == '0 && !last);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .start_col (start_col),
  .col_out   (col_out),
  .col_valid (col_valid),
  .last      (last),
  .mode_err  (mode_err),
  .run_full  (run_full)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       start_wr = 1'b0;
  logic [9:0] start_col = '0;
  logic [11:0] mode_word = '0;
  logic       stop = 1'b0;
  logic [9:0] col_out;
  logic       col_valid;
  logic       last;
  logic       mode_err;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  string tag = "R12";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_col(start_col), .mode_word(mode_word), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .last(last), .mode_err(mode_err)
  );

  // Behavioural reference: a queue of pending columns or a free-running page pointer.
  int q[$];
  bit fp_on = 0;
  int fp_addr = 0;
  bit exp_err = 0;

  // Beat count from the mode word; 0 means full page.
  function automatic int ref_beats(bit [11:0] m, bit wr, output bit bad);
    int n;
    bad = 0;
    case (m[2:0])
      3'd0: n = 1;
      3'd1: n = 2;
      3'd2: n = 4;
      3'd3: n = 8;
      3'd7: if (m[3]) begin n = 1; bad = 1; end else n = 0;
      default: begin n = 1; bad = 1; end
    endcase
    if (m[9] && wr) n = 1;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); fp_on = 0; fp_addr = 0; exp_err = 0;
    end else if (start) begin
      bit bad;
      int n;
      int s;
      n = ref_beats(mode_word, start_wr, bad);
      if (bad) exp_err = 1;
      s = int'(start_col);
      q.delete();
      fp_on = (n == 0);
      fp_addr = s;
      if (n != 0) begin
        for (int k = 0; k < n; k++) begin
          if (mode_word[3] && n > 1) q.push_back(s ^ k);
          else q.push_back((s - s % n) + ((s % n) + k) % n);
        end
      end
    end else if (fp_on || q.size() > 0) begin
      if (stop) begin
        q.delete(); fp_on = 0;
      end else if (fp_on) begin
        fp_addr = (fp_addr + 1) % 1024;
      end else begin
        void'(q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev; int ec; bit el;
      ev = fp_on || (q.size() > 0);
      ec = !ev ? 0 : (fp_on ? fp_addr : q[0]);
      el = !fp_on && (q.size() == 1);
      vectors++;
      if (col_valid !== ev || int'(col_out) != ec || last !== el || mode_err !== exp_err) begin
        misses++;
        $display("FAIL %s: valid/col/last/err = %0b/%0d/%0b/%0b expected %0b/%0d/%0b/%0b",
                 tag, col_valid, col_out, last, mode_err, ev, ec, el, exp_err);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic launch(bit wr, bit [11:0] m, bit [9:0] c);
    @(negedge clk);
    start = 1; start_wr = wr; mode_word = m; start_col = c;
    @(negedge clk);
    start = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop = 1;
    @(negedge clk);
    stop = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R12: reset state
    tag = "R12";
    vectors++;
    if (col_valid !== 0 || col_out !== 0 || last !== 0 || mode_err !== 0) begin
      misses++;
      $display("FAIL R12: reset outputs %0b/%0d/%0b/%0b expected 0/0/0/0",
               col_valid, col_out, last, mode_err);
    end
    tag = "R1";
    launch(0, 12'h000, 10'd40); idle(3);
    launch(0, 12'h001, 10'd41); idle(3);
    launch(0, 12'h002, 10'd40); idle(5);
    launch(0, 12'h003, 10'd40); idle(9);
    tag = "R2";
    launch(0, 12'h002, 10'd2);  idle(5);
    launch(0, 12'h001, 10'd7);  idle(3);
    launch(0, 12'h003, 10'd13); idle(9);
    tag = "R3";
    launch(0, 12'h00B, 10'd5);  idle(9);
    launch(1, 12'h00A, 10'd3);  idle(5);
    launch(0, 12'h009, 10'd10); idle(3);
    tag = "R4";
    launch(0, 12'h003, 10'h3FD); idle(9);
    launch(0, 12'h00B, 10'h2AE); idle(9);
    tag = "R5";
    launch(0, 12'h007, 10'd1020); idle(12);
    tag = "R10";
    pulse_stop(); idle(3);
    launch(0, 12'h003, 10'd16); idle(2);
    pulse_stop(); idle(3);
    tag = "R6";
    launch(0, 12'h008, 10'h155); idle(3);
    launch(0, 12'h000, 10'h3FF); idle(3);
    tag = "R7";
    launch(1, 12'h203, 10'd20); idle(4);
    launch(0, 12'h203, 10'd20); idle(9);
    launch(1, 12'h207, 10'd50); idle(3);
    tag = "R11";
    launch(0, 12'h003, 10'd64); idle(2);
    launch(0, 12'h00B, 10'd101); idle(3);
    launch(0, 12'h007, 10'd0); idle(1);
    launch(0, 12'h002, 10'd9); idle(5);
    tag = "R9";
    launch(0, 12'h007, 10'd500); idle(6);
    stop = 1; launch(0, 12'h001, 10'd1); stop = 0; idle(3);
    tag = "R8";
    launch(0, 12'h005, 10'd77); idle(3);
    launch(0, 12'h00F, 10'd78); idle(3);
    launch(0, 12'h003, 10'd8);  idle(9);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule